// File: doc/BRIEF.md
# Program Word Access Controller

This block gives a processor core byte-wide register access to single words of program memory. Software places a word address in two address registers and starts a read or a write from a control register. A read stalls instruction fetch for a fixed two cycles and leaves the fetched word in two data registers. A write sends the data registers to memory and keeps the core stalled until the memory reports that programming is finished. Clocks and everything outside the core keep running while the core is stalled.

Writes are guarded. A write starts only after a two-byte key has been written to a dedicated key register, immediately followed by a control write that sets the write-start bit while write enable is already on. Any break in that order, or a core interrupt during it, cancels the attempt. Completion of either kind of access raises a flag that software clears.

The memory array and its programming time are outside the block. They are reached through a simple synchronous port: a request with a write qualifier, read data one cycle after a read request, and a busy input that stays high while a write is being programmed.

Top module: `prog_word_access`

## Requirements
- R1: Register select codes are 0 address low byte, 1 address high byte (bits 4:0 used), 2 data low byte, 3 data high byte (bits 5:0 used), 4 control, 5 key. Reset clears every register, so all of them read back as zero.
- R2: Control bits: bit 7 selects program space and drives `mem_space`, bit 4 is the completion flag, bit 2 is write enable, bit 1 is write-start and reads 1 while a write runs, bit 0 is read-start and reads 1 while a read runs. At most one of bits 1 and 0 is ever set.
- R3: A control write with bit 0 set raises `stall` for exactly two cycles, starting in the cycle after the write. After that the word at the address is in the data registers and bit 0 reads 0.
- R4: A write is accepted only if the key register received 55h and then AAh, the next register write is a control write with bit 1 set, and bit 2 already held 1 before that control write.
- R5: An accepted write issues one request cycle with `mem_we` high. `stall` stays high from the cycle after the control write until the cycle after `mem_busy` falls, which is the busy length plus two cycles.
- R6: A key write that breaks the 55h, AAh order returns the key sequencer to idle. Any write to another register after AAh, other than the accepting control write, also returns it to idle.
- R7: When `core_irq` is high the key sequencer returns to idle. This takes priority over a key write in the same cycle.
- R8: A rejected write start produces no memory request and no stall, and bit 1 reads back 0.
- R9: Completion of either access sets the flag and raises `irq_flag`. A control write with bit 4 at 0 clears the flag. If completion and such a clear fall in the same cycle, the flag is set.
- R10: A write access leaves the address and data registers unchanged. A read access changes only the data registers.
- R11: The key register always reads 0.
- R12: While an access runs, register writes have no effect, except that a control write can still clear the flag.
- R13: If one control write sets both start bits and the write is accepted, only the write runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| core_irq | input | 1 | Core interrupt taken; cancels a key sequence |
| stall | output | 1 | Holds instruction fetch while an access runs |
| irq_flag | output | 1 | Completion flag |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_space | output | 1 | Program space select |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | WORD_W | Word to program |
| mem_rdata | input | WORD_W | Word read, valid one cycle after a read request |
| mem_busy | input | 1 | Write programming in progress |

## Verification
Two pairs of events can land in the same cycle. The first is a read's completion and a control write that clears the flag. The bench times that write to arrive exactly on the capture cycle and expects the flag to remain set, with the fetched word still captured. The second is a core interrupt and the AAh key write. The bench drives both on the same edge, then makes an otherwise valid write attempt, and expects no memory request, no stall and an unchanged word when it reads the address back.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

    localparam int BYTE_W = 8;

    localparam logic [2:0] SEL_ALO = 3'd0;
    localparam logic [2:0] SEL_AHI = 3'd1;
    localparam logic [2:0] SEL_DLO = 3'd2;
    localparam logic [2:0] SEL_DHI = 3'd3;
    localparam logic [2:0] SEL_CTL = 3'd4;
    localparam logic [2:0] SEL_KEY = 3'd5;

    localparam int CB_SPACE = 7;
    localparam int CB_DONE  = 4;
    localparam int CB_WREN  = 2;
    localparam int CB_WR    = 1;
    localparam int CB_RD    = 0;

    localparam logic [7:0] KEY_A = 8'h55;
    localparam logic [7:0] KEY_B = 8'hAA;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    typedef enum logic [2:0] {
        ACC_IDLE   = 3'd0,
        ACC_RD_REQ = 3'd1,
        ACC_RD_CAP = 3'd2,
        ACC_WR_REQ = 3'd3,
        ACC_WR_RUN = 3'd4
    } acc_state_e;

    typedef struct packed {
        logic space;
        logic done;
        logic wren;
    } ctl_t;

    function automatic logic [7:0] ctl_view(ctl_t c, logic wr_run, logic rd_run);
        logic [7:0] v;
        v = '0;
        v[CB_SPACE] = c.space;
        v[CB_DONE]  = c.done;
        v[CB_WREN]  = c.wren;
        v[CB_WR]    = wr_run;
        v[CB_RD]    = rd_run;
        return v;
    endfunction

endpackage

// File: rtl/pwa_key_seq.sv
module pwa_key_seq
    import pwa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ok,
    input  logic [2:0] sel,
    input  logic [7:0] wdata,
    input  logic       core_irq,
    output logic       armed
);

    key_state_e st, nx;

    always_comb begin
        nx = st;
        if (wr_ok) begin
            if (sel == SEL_KEY) begin
                if (st == KEY_IDLE && wdata == KEY_A)
                    nx = KEY_HALF;
                else if (st == KEY_HALF && wdata == KEY_B)
                    nx = KEY_ARMED;
                else
                    nx = KEY_IDLE;
            end else begin
                nx = KEY_IDLE;
            end
        end
        if (core_irq)
            nx = KEY_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= KEY_IDLE;
        else     st <= nx;
    end

    assign armed = (st == KEY_ARMED);

    p_irq_cancels_r7: assert property (@(posedge clk) disable iff (rst)
        core_irq |=> (st == KEY_IDLE));

    p_arm_after_pair_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(st) == KEY_HALF && $past(wr_ok) &&
                          $past(sel) == SEL_KEY && $past(wdata) == KEY_B));

endmodule

// File: rtl/pwa_access_fsm.sv
module pwa_access_fsm
    import pwa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_rd,
    input  logic start_wr,
    input  logic mem_busy,
    output logic busy,
    output logic rd_run,
    output logic wr_run,
    output logic mem_req,
    output logic mem_we,
    output logic capture,
    output logic done
);

    acc_state_e st, nx;

    always_comb begin
        nx = st;
        unique case (st)
            ACC_IDLE: begin
                if (start_wr)      nx = ACC_WR_REQ;
                else if (start_rd) nx = ACC_RD_REQ;
            end
            ACC_RD_REQ: nx = ACC_RD_CAP;
            ACC_RD_CAP: nx = ACC_IDLE;
            ACC_WR_REQ: nx = ACC_WR_RUN;
            ACC_WR_RUN: if (!mem_busy) nx = ACC_IDLE;
            default:    nx = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ACC_IDLE;
        else     st <= nx;
    end

    assign busy    = (st != ACC_IDLE);
    assign rd_run  = (st == ACC_RD_REQ) || (st == ACC_RD_CAP);
    assign wr_run  = (st == ACC_WR_REQ) || (st == ACC_WR_RUN);
    assign mem_req = (st == ACC_RD_REQ) || (st == ACC_WR_REQ);
    assign mem_we  = (st == ACC_WR_REQ);
    assign capture = (st == ACC_RD_CAP);
    assign done    = capture || (st == ACC_WR_RUN && !mem_busy);

    p_read_second_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ACC_RD_REQ) |=> (st == ACC_RD_CAP));

    p_read_ends_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ACC_RD_CAP) |=> (st == ACC_IDLE));

    p_write_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ACC_WR_RUN && mem_busy) |=> wr_run);

    p_one_kind_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_run, wr_run}));

endmodule

// File: rtl/prog_word_access.sv
module prog_word_access
    import pwa_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              core_irq,
    output logic              stall,
    output logic              irq_flag,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_space,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_busy
);

    localparam int AHI_W = ADDR_W - BYTE_W;
    localparam int DHI_W = WORD_W - BYTE_W;

    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    ctl_t              ctl_q;

    logic busy, rd_run, wr_run, capture, done, armed;
    logic wr_ok, ctl_wr, start_wr, start_rd;

    assign wr_ok    = reg_wr && !busy;
    assign ctl_wr   = reg_wr && (reg_sel == SEL_CTL);
    assign start_wr = wr_ok && (reg_sel == SEL_CTL) && reg_wdata[CB_WR] && ctl_q.wren && armed;
    assign start_rd = wr_ok && (reg_sel == SEL_CTL) && reg_wdata[CB_RD] && !start_wr;

    pwa_key_seq u_key (
        .clk      (clk),
        .rst      (rst),
        .wr_ok    (wr_ok),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .core_irq (core_irq),
        .armed    (armed)
    );

    pwa_access_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_rd (start_rd),
        .start_wr (start_wr),
        .mem_busy (mem_busy),
        .busy     (busy),
        .rd_run   (rd_run),
        .wr_run   (wr_run),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .capture  (capture),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            ctl_q  <= '0;
        end else begin
            if (wr_ok) begin
                unique case (reg_sel)
                    SEL_ALO: addr_q[BYTE_W-1:0]      <= reg_wdata;
                    SEL_AHI: addr_q[ADDR_W-1:BYTE_W] <= reg_wdata[AHI_W-1:0];
                    SEL_DLO: data_q[BYTE_W-1:0]      <= reg_wdata;
                    SEL_DHI: data_q[WORD_W-1:BYTE_W] <= reg_wdata[DHI_W-1:0];
                    SEL_CTL: begin
                        ctl_q.space <= reg_wdata[CB_SPACE];
                        ctl_q.wren  <= reg_wdata[CB_WREN];
                    end
                    default: ;
                endcase
            end
            if (capture)
                data_q <= mem_rdata;
            if (done)
                ctl_q.done <= 1'b1;
            else if (ctl_wr && !reg_wdata[CB_DONE])
                ctl_q.done <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_ALO: reg_rdata = addr_q[BYTE_W-1:0];
            SEL_AHI: reg_rdata[AHI_W-1:0] = addr_q[ADDR_W-1:BYTE_W];
            SEL_DLO: reg_rdata = data_q[BYTE_W-1:0];
            SEL_DHI: reg_rdata[DHI_W-1:0] = data_q[WORD_W-1:BYTE_W];
            SEL_CTL: reg_rdata = ctl_view(ctl_q, wr_run, rd_run);
            default: reg_rdata = '0;
        endcase
    end

    assign stall     = busy;
    assign irq_flag  = ctl_q.done;
    assign mem_space = ctl_q.space;
    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;

    p_flag_on_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> irq_flag);

    p_addr_kept_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q));

    p_data_kept_r10: assert property (@(posedge clk) disable iff (rst)
        wr_run |=> $stable(data_q));

    p_write_needs_key_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ($past(armed) && $past(ctl_q.wren)));

    p_key_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == SEL_KEY) |-> (reg_rdata == 8'h00));

endmodule

// File: tb/sim_prog_word_access.sv
module sim_prog_word_access;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 13;
    localparam int WORD_W = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_sel = 3'd0;
    logic [7:0]        reg_wdata = 8'd0;
    logic [7:0]        reg_rdata;
    logic              core_irq = 1'b0;
    logic              stall, irq_flag, mem_req, mem_we, mem_space;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;
    logic              mem_busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int busy_len = 3;
    int wr_reqs = 0;

    logic [WORD_W-1:0] model [256];
    logic [WORD_W-1:0] expect_mem [256];
    int                busy_cnt;
    logic [7:0]        pend_a;
    logic [WORD_W-1:0] pend_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_word_access u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_irq(core_irq),
        .stall(stall), .irq_flag(irq_flag), .mem_req(mem_req), .mem_we(mem_we),
        .mem_space(mem_space), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_busy(mem_busy)
    );

    function automatic logic [WORD_W-1:0] seed_word(int i);
        return WORD_W'((i * 613 + 91) ^ (i << 6));
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            for (int i = 0; i < 256; i++) model[i] <= seed_word(i);
            mem_busy  <= 1'b0;
            busy_cnt  <= 0;
            mem_rdata <= '0;
        end else begin
            if (mem_req && !mem_we) mem_rdata <= model[mem_addr[7:0]];
            if (mem_req && mem_we) begin
                wr_reqs  <= wr_reqs + 1;
                mem_busy <= 1'b1;
                busy_cnt <= busy_len;
                pend_a   <= mem_addr[7:0];
                pend_d   <= mem_wdata;
            end else if (mem_busy) begin
                if (busy_cnt == 1) begin
                    mem_busy      <= 1'b0;
                    model[pend_a] <= pend_d;
                end
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wreg(logic [2:0] s, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(logic [2:0] s, output logic [7:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic count_stall(output int n);
        n = 0;
        while (stall && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_addr(logic [ADDR_W-1:0] a);
        wreg(3'd0, a[7:0]);
        wreg(3'd1, 8'(a[ADDR_W-1:8]));
    endtask

    task automatic read_word(logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] w, output int n);
        logic [7:0] lo, hi;
        set_addr(a);
        wreg(3'd4, 8'h91);
        count_stall(n);
        rreg(3'd2, lo);
        rreg(3'd3, hi);
        w = {hi[5:0], lo};
    endtask

    task automatic load_data(logic [WORD_W-1:0] w);
        wreg(3'd2, w[7:0]);
        wreg(3'd3, 8'(w[WORD_W-1:8]));
    endtask

    task automatic good_write(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] w, output int n);
        set_addr(a);
        load_data(w);
        wreg(3'd4, 8'h94);
        wreg(3'd5, 8'h55);
        wreg(3'd5, 8'hAA);
        wreg(3'd4, 8'h96);
        count_stall(n);
    endtask

    task automatic expect_rejected(string req, logic [ADDR_W-1:0] a, int reqs_before);
        logic [7:0] c;
        logic [WORD_W-1:0] w;
        int n;
        chk(req, {31'd0, stall}, 32'd0);
        rreg(3'd4, c);
        chk(req, {31'd0, c[1]}, 32'd0);
        repeat (3) @(negedge clk);
        chk(req, 32'(wr_reqs), 32'(reqs_before));
        read_word(a, w, n);
        chk(req, 32'(w), 32'(expect_mem[a[7:0]]));
    endtask

    initial begin
        int wd;
        wd = 0;
        while (wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected below %0d", wd, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [WORD_W-1:0] w, d;
        logic [ADDR_W-1:0] a;
        int n, r0, unused;
        unused = $urandom(32'h5EED1);
        for (int i = 0; i < 256; i++) expect_mem[i] = seed_word(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 6; s++) begin
            rreg(3'(s), v);
            chk("R1", 32'(v), 32'd0);
        end
        chk("R1", {30'd0, stall, irq_flag}, 32'd0);

        // R3 read timing and data
        a = 13'h1234;
        read_word(a, w, n);
        chk("R3", 32'(n), 32'd2);
        chk("R3", 32'(w), 32'(expect_mem[a[7:0]]));
        rreg(3'd4, v);
        chk("R3", {24'd0, v}, 32'h90);
        chk("R2", {31'd0, mem_space}, 32'd1);
        chk("R9", {31'd0, irq_flag}, 32'd1);
        rreg(3'd0, v);
        chk("R10", 32'(v), 32'h34);
        rreg(3'd1, v);
        chk("R10", 32'(v), 32'h12);

        // R9 clear
        wreg(3'd4, 8'h00);
        chk("R9", {31'd0, irq_flag}, 32'd0);

        // R11 key reads zero after a key write
        wreg(3'd5, 8'h55);
        rreg(3'd5, v);
        chk("R11", 32'(v), 32'd0);

        // R5 R10 directed write
        busy_len = 5;
        a = 13'h0A07;
        good_write(a, 14'h2ABC, n);
        expect_mem[a[7:0]] = 14'h2ABC;
        chk("R5", 32'(n), 32'(busy_len + 2));
        chk("R9", {31'd0, irq_flag}, 32'd1);
        rreg(3'd2, v);
        chk("R10", 32'(v), 32'hBC);
        rreg(3'd3, v);
        chk("R10", 32'(v), 32'h2A);
        rreg(3'd0, v);
        chk("R10", 32'(v), 32'h07);
        read_word(a, w, n);
        chk("R5", 32'(w), 32'h2ABC);

        // R8 write without enable
        a = 13'h0011;
        set_addr(a); load_data(14'h0F0F);
        wreg(3'd4, 8'h90);
        r0 = wr_reqs;
        wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA);
        wreg(3'd4, 8'h92);
        expect_rejected("R8", a, r0);

        // R6 broken key order
        a = 13'h0022;
        set_addr(a); load_data(14'h1111);
        wreg(3'd4, 8'h94);
        r0 = wr_reqs;
        wreg(3'd5, 8'h55); wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA);
        wreg(3'd4, 8'h96);
        expect_rejected("R6", a, r0);

        // R6 other register write between key and start
        a = 13'h0033;
        set_addr(a); load_data(14'h2222);
        wreg(3'd4, 8'h94);
        r0 = wr_reqs;
        wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA);
        wreg(3'd2, 8'h22);
        wreg(3'd4, 8'h96);
        expect_rejected("R6", a, r0);

        // R7 interrupt between the key bytes
        a = 13'h0044;
        set_addr(a); load_data(14'h3333);
        wreg(3'd4, 8'h94);
        r0 = wr_reqs;
        wreg(3'd5, 8'h55);
        core_irq = 1'b1; @(negedge clk); core_irq = 1'b0;
        wreg(3'd5, 8'hAA);
        wreg(3'd4, 8'h96);
        expect_rejected("R7", a, r0);

        // R7 interrupt on the same edge as the second key byte
        a = 13'h0055;
        set_addr(a); load_data(14'h3A3A);
        wreg(3'd4, 8'h94);
        r0 = wr_reqs;
        wreg(3'd5, 8'h55);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 3'd5; reg_wdata = 8'hAA; core_irq = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; core_irq = 1'b0;
        wreg(3'd4, 8'h96);
        expect_rejected("R7", a, r0);

        // R9 completion and flag clear on the same cycle
        wreg(3'd4, 8'h00);
        a = 13'h0066;
        set_addr(a);
        wreg(3'd4, 8'h01);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 8'h00;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R9", {31'd0, irq_flag}, 32'd1);
        rreg(3'd2, v);
        chk("R12", 32'(v), 32'(expect_mem[8'h66][7:0]));

        // R12 writes during a write access
        busy_len = 6;
        a = 13'h0077;
        set_addr(a); load_data(14'h0777);
        wreg(3'd4, 8'h94);
        wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA);
        wreg(3'd4, 8'h96);
        wreg(3'd0, 8'hEE);
        wreg(3'd2, 8'hEE);
        count_stall(n);
        expect_mem[a[7:0]] = 14'h0777;
        rreg(3'd0, v);
        chk("R12", 32'(v), 32'h77);
        rreg(3'd2, v);
        chk("R12", 32'(v), 32'h77);

        // R13 both start bits with a valid key
        busy_len = 2;
        a = 13'h0088;
        set_addr(a); load_data(14'h1888);
        wreg(3'd4, 8'h94);
        r0 = wr_reqs;
        wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA);
        wreg(3'd4, 8'h97);
        count_stall(n);
        expect_mem[a[7:0]] = 14'h1888;
        chk("R13", 32'(wr_reqs), 32'(r0 + 1));
        chk("R13", 32'(n), 32'(busy_len + 2));
        read_word(a, w, n);
        chk("R13", 32'(w), 32'h1888);

        // R3 R4 R5 random mix
        for (int k = 0; k < 30; k++) begin
            a = ADDR_W'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                read_word(a, w, n);
                chk("R3", 32'(n), 32'd2);
                chk("R3", 32'(w), 32'(expect_mem[a[7:0]]));
            end else begin
                busy_len = $urandom_range(1, 9);
                d = WORD_W'($urandom);
                good_write(a, d, n);
                expect_mem[a[7:0]] = d;
                chk("R4", 32'(n), 32'(busy_len + 2));
                read_word(a, w, n);
                chk("R5", 32'(w), 32'(d));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule